// File: doc/BRIEF.md
# Serial-Loaded Latched Channel Driver Controller

This block accepts a slow serial stream (clock, data and an active-low load strobe) and presents a bank of channel drive states to a row of output drivers. Bits enter an internal shift register only while the load strobe is held low. When the strobe returns high, the whole register is copied into an output latch. An enable input gates the latched pattern onto the channels. A power-state input reports that the supply is shut down or still ramping. While it is asserted, it overrides everything and floats every channel.

The serial clock, the strobe, the serial data and the output enable are brought into the system clock domain through two-flop synchronizers. Edges are detected in that domain, so the system clock must run at least eight times faster than the serial clock. For a 1 MHz serial clock, 8 MHz is the minimum. Each channel reports a 2-bit drive code. The power-state input acts combinationally on the outputs.

Top module: `serial_latch_driver`

## Requirements
- R1: While the synchronized load strobe is high, serial clock edges and serial data have no effect: the shift register holds its value, and a later latch transfer shows the earlier contents.
- R2: The shift register is copied into the output latch only on a low-to-high transition of the load strobe. While bits are being shifted, the channel outputs keep the previously latched pattern.
- R3: With output enable low and the power-state input low, every channel reports drive-low (code 2'b00).
- R4: With output enable high and the power-state input low, channel i reports drive-high (code 2'b01) when latch bit i is 1, and drive-low (2'b00) when it is 0. Channel i occupies bits [2i+1:2i] of the output bus.
- R5: While the power-state input is high, every channel reports high-impedance (code 2'b10), whatever the value of output enable.
- R6: Data is sampled on the rising serial clock edge and moves toward higher channel indices. After NUM_CH edges, the first bit shifted ends in channel NUM_CH-1 and the last bit in channel 0.
- R7: When more than NUM_CH bits are shifted before a transfer, only the last NUM_CH bits are kept.
- R8: When k < NUM_CH bits are shifted, the earlier register contents move up k positions and the new bits fill channels k-1 down to 0.
- R9: After reset the shift register and latch are all zeros, so all channels report drive-low once the power-state input is low.
- R10: Toggling output enable never changes the latch or shift register: restoring it brings back the same pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_load_n | input | 1 | Active-low load strobe; rising edge transfers to latch |
| out_en | input | 1 | Output enable gating the latched pattern |
| pwr_hold | input | 1 | Shutdown/soft-start status; forces all channels high-impedance |
| chan_state | output | 2*NUM_CH | Per-channel drive code: 00 low, 01 high, 10 high-impedance |

## Verification
The bench builds the block with NUM_CH = 5, which makes all 32 latch patterns reachable in one run. Each pattern is checked with enable high, with enable low, and under the power-state override. The small width also keeps short runs of overlong and short shift sequences cheap. That brings the keep-last-bits and partial-shift rules (R7, R8) within reach next to the full sweep.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_HIZ  = 2'b10
  } drv_code_e;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sld_shifter.sv
module sld_shifter #(
  parameter int unsigned NUM_CH = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              load_n_s,
  output logic [NUM_CH-1:0] shift_o,
  output logic [NUM_CH-1:0] latch_o
);
  logic              sclk_prev_q, load_prev_q;
  logic [NUM_CH-1:0] shift_q, shift_d;
  logic [NUM_CH-1:0] latch_q, latch_d;
  logic              shift_en, latch_en;

  assign shift_en = sclk_s & ~sclk_prev_q & ~load_n_s;
  assign latch_en = load_n_s & ~load_prev_q;

  always_comb begin
    shift_d = shift_q;
    if (shift_en) begin
      if (NUM_CH > 1) shift_d = {shift_q[NUM_CH-2:0], sdata_s};
      else            shift_d = sdata_s;
    end
    latch_d = latch_q;
    if (latch_en) latch_d = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      load_prev_q <= 1'b1;
      shift_q     <= '0;
      latch_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      load_prev_q <= load_n_s;
      shift_q     <= shift_d;
      latch_q     <= latch_d;
    end
  end

  assign shift_o = shift_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/sld_out_gate.sv
module sld_out_gate
  import sld_pkg::*;
#(
  parameter int unsigned NUM_CH = 21
) (
  input  logic [NUM_CH-1:0]   latch_i,
  input  logic                oe_i,
  input  logic                hold_i,
  output logic [2*NUM_CH-1:0] state_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    drv_code_e code;
    always_comb begin
      if (hold_i)                code = DRV_HIZ;
      else if (oe_i && latch_i[c]) code = DRV_HIGH;
      else                       code = DRV_LOW;
    end
    assign state_o[2*c +: 2] = code;
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int unsigned NUM_CH      = 21,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk,
  input  logic                ser_data,
  input  logic                ser_load_n,
  input  logic                out_en,
  input  logic                pwr_hold,
  output logic [2*NUM_CH-1:0] chan_state
);
  localparam int unsigned NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0100;

  logic [NSYNC-1:0]  raw_in, synced;
  logic              sclk_sync, sdata_sync, le_sync, oe_sync;
  logic [NUM_CH-1:0] shift_q, latch_q;

  assign raw_in = {out_en, ser_load_n, ser_data, ser_clk};

  sld_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(synced)
  );

  assign sclk_sync  = synced[0];
  assign sdata_sync = synced[1];
  assign le_sync    = synced[2];
  assign oe_sync    = synced[3];

  sld_shifter #(.NUM_CH(NUM_CH)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_sync), .sdata_s(sdata_sync),
    .load_n_s(le_sync), .shift_o(shift_q), .latch_o(latch_q)
  );

  sld_out_gate #(.NUM_CH(NUM_CH)) u_gate (
    .latch_i(latch_q), .oe_i(oe_sync), .hold_i(pwr_hold), .state_o(chan_state)
  );
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int unsigned NUM_CH = 21
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_hold,
  input logic                oe_sync,
  input logic                le_sync,
  input logic [NUM_CH-1:0]   shift_q,
  input logic [NUM_CH-1:0]   latch_q,
  input logic [2*NUM_CH-1:0] chan_state
);
  logic any_high;
  always_comb begin
    any_high = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (chan_state[2*c +: 2] == 2'b01) any_high = 1'b1;
  end

  // R5
  hold_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_hold |-> (chan_state == {NUM_CH{2'b10}}));

  // R3
  oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_sync && !pwr_hold) |-> !any_high);

  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_sync |=> $stable(shift_q));

  // R2
  latch_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(le_sync) |=> $stable(latch_q));
endmodule

bind serial_latch_driver sld_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_hold(pwr_hold), .oe_sync(oe_sync),
  .le_sync(le_sync), .shift_q(shift_q), .latch_q(latch_q), .chan_state(chan_state)
);

// File: tb/serial_latch_driver_bench.sv
module serial_latch_driver_bench;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load_n = 1'b1, out_en = 1'b0, pwr_hold = 1'b0;
  logic [2*N-1:0] chan_state;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_sr = '0;
  logic [N-1:0] exp_lat = '0;

  always #4 clk = ~clk;

  serial_latch_driver #(.NUM_CH(N)) u_serial_latch_driver (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load_n(ser_load_n), .out_en(out_en), .pwr_hold(pwr_hold),
    .chan_state(chan_state)
  );

  function automatic logic [2*N-1:0] expect_out(logic [N-1:0] lat, logic oe, logic hold);
    logic [2*N-1:0] r;
    for (int c = 0; c < N; c++)
      r[2*c +: 2] = hold ? 2'b10 : ((oe && lat[c]) ? 2'b01 : 2'b00);
    return r;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [2*N-1:0] exp);
    wait_clk(6);
    checks++;
    if (chan_state !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, chan_state, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    ser_load_n = 1'b0;
    ser_data = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
    wait_clk(4);
    exp_sr = {exp_sr[N-2:0], b};
  endtask

  task automatic strobe();
    ser_load_n = 1'b0;
    wait_clk(4);
    ser_load_n = 1'b1;
    wait_clk(6);
    exp_lat = exp_sr;
  endtask

  task automatic shift_word(logic [N-1:0] w);
    for (int i = N - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  initial begin
    out_en = 1'b1;
    wait_clk(3);
    rst_n = 1'b1;
    // R9 reset state
    check("R9", expect_out('0, 1'b1, 1'b0));

    for (int p = 0; p < (1 << N); p++) begin
      shift_word(p[N-1:0]);
      // R2 old pattern shown until strobe rises
      check("R2", expect_out(exp_lat, 1'b1, 1'b0));
      strobe();
      // R4 R6 first bit ends at highest channel
      check("R4/R6", expect_out(p[N-1:0], 1'b1, 1'b0));
      out_en = 1'b0;
      check("R3", expect_out(exp_lat, 1'b0, 1'b0));
      pwr_hold = 1'b1;
      check("R5 oe0", expect_out(exp_lat, 1'b0, 1'b1));
      out_en = 1'b1;
      check("R5 oe1", expect_out(exp_lat, 1'b1, 1'b1));
      pwr_hold = 1'b0;
      // R10 pattern restored after enable toggling
      check("R10", expect_out(p[N-1:0], 1'b1, 1'b0));
    end

    // R1: clock edges with strobe high are ignored
    shift_word(5'b10110);
    strobe();
    ser_load_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ser_data = 1'b1; wait_clk(4); ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0; wait_clk(4);
    end
    strobe();
    check("R1", expect_out(5'b10110, 1'b1, 1'b0));

    // R7: 8 bits shifted, last 5 kept
    for (int i = 7; i >= 0; i--) shift_bit(logic'((8'b1110_1001 >> i) & 1));
    strobe();
    check("R7", expect_out(5'b01001, 1'b1, 1'b0));

    // R8: 2 more bits move earlier contents up by two
    shift_bit(1'b1);
    shift_bit(1'b0);
    strobe();
    check("R8", expect_out(5'b00110, 1'b1, 1'b0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule